// File: doc/BRIEF.md
# Dithered PWM Timer with Trip Override

An 8-bit timer/counter that counts enable pulses from one of twelve selectable sources and compares the count with a double-buffered compare value. It runs in one of three modes: a match-and-toggle mode, a PWM mode, and a gate-width capture mode. The toggle mode gives interval interrupts and a square wave. When the event input is selected as the count source, the toggle mode counts external events. The PWM mode has a fixed 256-count period. Its duty is refined by a 2-bit fraction, which lengthens the high time of chosen periods within a repeating frame of four periods.

A trip input is synchronized and watched for a falling edge. When protection is armed, such an edge latches an override. The override drives the pin high, drives it low, or releases it to high impedance by dropping the output enable. The override holds until software clears it. Configuration goes through a small synchronous write port. The running count is visible on `count_o`, which is also where a measured gate width is read.

Top module: `dither_timer`

## Requirements
- R1: After reset `tmr_o` is 0, `tmr_oe_o` is 1, `irq_o` is 0 and `count_o` is 0.
- R2: Control register (address 0) holds mode in bits [1:0], source in bits [5:2] and run in bit 6. Source values 0..10 count on `tick_i[source]`; value 11 counts synchronized event edges; values 12..15 never count. Ticks on unselected lines have no effect.
- R3: Modes 0 and 3 (toggle): each selected tick advances the count. A tick that finds the count equal to the active compare value returns the count to 0, inverts `tmr_o` and raises `irq_o` for one clock. The interrupt period is therefore compare+1 ticks.
- R4: A write to the compare buffer (address 1) reaches the active compare only at a reload point: a toggle-mode match or a PWM wrap. While run is 0, the count is held at 0, the output is 0, and the active compare follows the buffer.
- R5: With source 11, each rising edge of `event_i` (passed through a two-stage synchronizer) counts once, and `tick_i` is ignored.
- R6: Mode 1 (PWM): the count runs 0..255 and then wraps. `tmr_o` is high while count < compare + extra. Each wrap reloads the compare and raises `irq_o` for one clock.
- R7: The fraction field (address 2, bits [1:0]) sets extra=1 in these periods of each four-period frame, counting from run start. Value 0: none. Value 1: period 0. Value 2: periods 0 and 2. Value 3: periods 0, 1 and 2.
- R8: Mode 2 (gate width): a synchronized rising edge of `gate_i` restarts the count. Ticks are counted while the gate is high, saturating at 255. A falling edge holds the count and raises `irq_o` for one clock. `tmr_o` stays 0.
- R9: Protection register (address 3) holds the state in bits [1:0] (0 high, 1 low, 2 or 3 high impedance), arm in bit 2, and clear in bit 3 (a write of 1 clears). A synchronized falling edge of `trip_n_i` while armed latches the override. The latch holds until cleared, and the pin shows the chosen state. High impedance gives `tmr_oe_o`=0 and `tmr_o`=0.
- R10: A falling trip edge while disarmed and a rising trip edge both leave the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| tick_i | input | 11 | Prescaled count enables, one per internal source |
| event_i | input | 1 | External event input (asynchronous) |
| gate_i | input | 1 | Gate for width capture (asynchronous) |
| trip_n_i | input | 1 | Trip line, falling edge active (asynchronous) |
| tmr_o | output | 1 | Timer output pin value |
| tmr_oe_o | output | 1 | Timer output enable |
| irq_o | output | 1 | One-clock interrupt pulse |
| count_o | output | 8 | Current count / captured width |

## Verification
A register write or a selected tick changes the state on the clock edge that samples it. The bench drives inputs on falling edges and reads the result at the next falling edge. The asynchronous inputs (event, gate and trip) pass through two synchronizer stages plus an edge-detect register, so their effect lands on the third rising edge after the change. The bench waits four or more cycles before judging those results. PWM high time is summed over exactly 256 samples per period, starting at the first falling edge after the run bit is written, so each period of the four-period frame is attributed exactly. Interrupt intervals are measured edge to edge, which removes the start-up offset.

// File: rtl/dither_timer_pkg.sv
package dither_timer_pkg;
  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'd0,
    MODE_PWM    = 2'd1,
    MODE_WIDTH  = 2'd2,
    MODE_ALT    = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    TRIP_HIGH = 2'd0,
    TRIP_LOW  = 2'd1,
    TRIP_HIZ  = 2'd2,
    TRIP_HIZ2 = 2'd3
  } trip_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_FRAC = 2'd2;
  localparam logic [1:0] ADDR_TRIP = 2'd3;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // R5
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel #(
  parameter int unsigned NUM_TICK = 11,
  localparam int unsigned SEL_W   = $clog2(NUM_TICK + 1),
  localparam int unsigned NUM_SEL = 2 ** SEL_W
) (
  input  logic [NUM_TICK-1:0] tick_i,
  input  logic                evt_rise_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                tick_o
);
  logic [NUM_SEL-1:0] src_vec;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_src
    if (g < NUM_TICK) begin : g_int
      assign src_vec[g] = tick_i[g];
    end else if (g == NUM_TICK) begin : g_evt
      assign src_vec[g] = evt_rise_i;
    end else begin : g_off
      assign src_vec[g] = 1'b0;
    end
  end

  assign tick_o = src_vec[sel_i];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import dither_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned ADD_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  tmr_mode_e        mode_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  input  logic [ADD_W-1:0] frac_i,
  input  logic             gate_lvl_i,
  input  logic             gate_rise_i,
  input  logic             gate_fall_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cmp_act_q;
  logic [ADD_W-1:0] frame_q, frame_rev;
  logic             tog_q, irq_q;
  logic             is_pwm, is_width, match, wrap, reload, extra, pwm_hi;
  logic [CNT_W:0]   duty;

  assign is_pwm   = (mode_i == MODE_PWM);
  assign is_width = (mode_i == MODE_WIDTH);
  assign match    = (cnt_q == cmp_act_q);
  assign wrap     = (cnt_q == CNT_MAX);
  assign reload   = run_i && tick_i && !is_width && (is_pwm ? wrap : match);

  // bit-reversed frame index spreads the extra counts evenly
  for (genvar g = 0; g < ADD_W; g++) begin : g_rev
    assign frame_rev[g] = frame_q[ADD_W-1-g];
  end
  assign extra  = (frame_rev < frac_i);
  assign duty   = {1'b0, cmp_act_q} + {{CNT_W{1'b0}}, extra};
  assign pwm_hi = ({1'b0, cnt_q} < duty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      cmp_act_q <= '0;
      frame_q   <= '0;
      tog_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else if (!run_i) begin
      cnt_q     <= '0;
      cmp_act_q <= cmp_buf_i;
      frame_q   <= '0;
      tog_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (is_width) begin
        if (gate_rise_i) begin
          cnt_q <= {{(CNT_W-1){1'b0}}, tick_i};
        end else if (gate_lvl_i && tick_i && !wrap) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        if (gate_fall_i) irq_q <= 1'b1;
      end else if (tick_i) begin
        if (reload) begin
          cnt_q     <= '0;
          cmp_act_q <= cmp_buf_i;
          irq_q     <= 1'b1;
          if (is_pwm) frame_q <= frame_q + ADD_W'(1);
          else        tog_q   <= ~tog_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    wave_o = 1'b0;
    if (run_i) begin
      if (is_pwm)         wave_o = pwm_hi;
      else if (!is_width) wave_o = tog_q;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R4
  cmp_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && (cmp_act_q != $past(cmp_act_q))) |-> $past(reload));

  // R3
  match_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && mode_i == MODE_TOGGLE && $stable(mode_i) && irq_q)
      |-> cnt_q == '0);

  // R8
  width_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && is_width && $stable(mode_i) &&
     $past(cnt_q) == CNT_MAX && !$past(gate_rise_i)) |-> cnt_q == CNT_MAX);
endmodule

// File: rtl/tmr_trip.sv
module tmr_trip
  import dither_timer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fall_i,
  input  logic        arm_i,
  input  logic        clr_i,
  input  trip_state_e state_i,
  input  logic        wave_i,
  output logic        pin_o,
  output logic        oe_o
);
  logic latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               latched_q <= 1'b0;
    else if (fall_i && arm_i)  latched_q <= 1'b1;
    else if (clr_i)            latched_q <= 1'b0;
  end

  always_comb begin
    pin_o = wave_i;
    oe_o  = 1'b1;
    if (latched_q) begin
      case (state_i)
        TRIP_HIGH: pin_o = 1'b1;
        TRIP_LOW:  pin_o = 1'b0;
        default: begin
          pin_o = 1'b0;
          oe_o  = 1'b0;
        end
      endcase
    end
  end

  // R9
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_q && !clr_i) |=> latched_q);

  // R10
  latch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latched_q) |-> $past(fall_i && arm_i));
endmodule

// File: rtl/dither_timer.sv
module dither_timer
  import dither_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned ADD_W       = 2,
  parameter int unsigned NUM_TICK    = 11,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_TICK + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_addr_i,
  input  logic [CNT_W-1:0]    cfg_wdata_i,
  input  logic [NUM_TICK-1:0] tick_i,
  input  logic                event_i,
  input  logic                gate_i,
  input  logic                trip_n_i,
  output logic                tmr_o,
  output logic                tmr_oe_o,
  output logic                irq_o,
  output logic [CNT_W-1:0]    count_o
);
  localparam int unsigned RUN_BIT = SEL_W + 2;

  tmr_mode_e        mode_q;
  logic [SEL_W-1:0] src_q;
  logic             run_q;
  logic [CNT_W-1:0] cmp_buf_q;
  logic [ADD_W-1:0] frac_q;
  trip_state_e      tstate_q;
  logic             arm_q;
  logic             trip_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TOGGLE;
      src_q     <= '0;
      run_q     <= 1'b0;
      cmp_buf_q <= '0;
      frac_q    <= '0;
      tstate_q  <= TRIP_HIGH;
      arm_q     <= 1'b0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        ADDR_CTRL: begin
          mode_q <= tmr_mode_e'(cfg_wdata_i[1:0]);
          src_q  <= cfg_wdata_i[SEL_W+1:2];
          run_q  <= cfg_wdata_i[RUN_BIT];
        end
        ADDR_CMP:  cmp_buf_q <= cfg_wdata_i;
        ADDR_FRAC: frac_q    <= cfg_wdata_i[ADD_W-1:0];
        default: begin
          tstate_q <= trip_state_e'(cfg_wdata_i[1:0]);
          arm_q    <= cfg_wdata_i[2];
        end
      endcase
    end
  end

  assign trip_clr = cfg_we_i && (cfg_addr_i == ADDR_TRIP) && cfg_wdata_i[3];

  logic evt_lvl, evt_rise, evt_fall;
  logic gate_lvl, gate_rise, gate_fall;
  logic trip_lvl, trip_rise, trip_fall;
  logic sync_unused;
  assign sync_unused = evt_lvl ^ evt_fall ^ trip_lvl ^ trip_rise;

  tmr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_evt_sync (
    .clk_i, .rst_ni, .async_i(event_i),
    .level_o(evt_lvl), .rise_o(evt_rise), .fall_o(evt_fall)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gate_sync (
    .clk_i, .rst_ni, .async_i(gate_i),
    .level_o(gate_lvl), .rise_o(gate_rise), .fall_o(gate_fall)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_trip_sync (
    .clk_i, .rst_ni, .async_i(trip_n_i),
    .level_o(trip_lvl), .rise_o(trip_rise), .fall_o(trip_fall)
  );

  logic tick_sel;

  tmr_clk_sel #(.NUM_TICK(NUM_TICK)) u_clk_sel (
    .tick_i(tick_i), .evt_rise_i(evt_rise), .sel_i(src_q), .tick_o(tick_sel)
  );

  logic wave;

  tmr_core #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_core (
    .clk_i, .rst_ni,
    .run_i(run_q), .mode_i(mode_q), .tick_i(tick_sel),
    .cmp_buf_i(cmp_buf_q), .frac_i(frac_q),
    .gate_lvl_i(gate_lvl), .gate_rise_i(gate_rise), .gate_fall_i(gate_fall),
    .cnt_o(count_o), .wave_o(wave), .irq_o(irq_o)
  );

  tmr_trip u_trip (
    .clk_i, .rst_ni,
    .fall_i(trip_fall), .arm_i(arm_q), .clr_i(trip_clr),
    .state_i(tstate_q), .wave_i(wave),
    .pin_o(tmr_o), .oe_o(tmr_oe_o)
  );
endmodule

// File: tb/dither_timer_tb.sv
module dither_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [10:0] tick_i = '0;
  logic        event_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        trip_n_i = 1'b1;
  logic        tmr_o, tmr_oe_o, irq_o;
  logic [7:0]  count_o;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  dither_timer u_dut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .tick_i, .event_i, .gate_i, .trip_n_i,
    .tmr_o, .tmr_oe_o, .irq_o, .count_o
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) if (irq_o) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input int mode, input int src, input bit run);
    return {1'b0, run, src[3:0], mode[1:0]};
  endfunction

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!irq_o && n < 5000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, n1, n2, t0, t1, hi, base, w;
    idle(3);
    // R1 reset state
    chk("R1 tmr_o", tmr_o, 0);
    chk("R1 oe", tmr_oe_o, 1);
    chk("R1 irq", irq_o, 0);
    chk("R1 count", count_o, 0);
    rst_ni = 1'b1;
    idle(2);

    // R2 source select sweep
    wr(1, 8'd255);
    for (int s = 0; s < 11; s++) begin
      wr(0, ctl(0, s, 0));
      wr(0, ctl(0, s, 1));
      tick_i = 11'(1 << s);
      idle(20);
      tick_i = '0;
      chk($sformatf("R2 src %0d selected", s), count_o, 20);
      tick_i = ~11'(1 << s);
      idle(20);
      tick_i = '0;
      chk($sformatf("R2 src %0d others ignored", s), count_o, 20);
    end
    for (int s = 12; s < 16; s++) begin
      wr(0, ctl(0, s, 0));
      wr(0, ctl(0, s, 1));
      tick_i = '1;
      idle(20);
      chk($sformatf("R2 src %0d off", s), count_o, 0);
    end

    // R3 toggle period sweep
    tick_i = '1;
    foreach (n_arr_c[i]) begin
      wr(0, ctl(0, 0, 0));
      wr(1, 8'(n_arr_c[i]));
      wr(0, ctl(0, 0, 1));
      wait_irq(n);
      t0 = tmr_o;
      chk("R3 first toggle high", t0, 1);
      wait_irq(n);
      t1 = tmr_o;
      chk($sformatf("R3 period cmp=%0d", n_arr_c[i]), n, n_arr_c[i] + 1);
      chk("R3 output toggles", t1, 1 - t0);
      idle(1);
      if (n_arr_c[i] > 0) chk("R3 irq one clock", irq_o, 0);
    end
    // alternate mode code behaves as toggle
    wr(0, ctl(0, 0, 0));
    wr(1, 8'd6);
    wr(0, ctl(3, 0, 1));
    wait_irq(n);
    wait_irq(n);
    chk("R3 mode 3 period", n, 7);

    // R4 double buffer
    wr(0, ctl(0, 0, 0));
    wr(1, 8'd9);
    wr(0, ctl(0, 0, 1));
    wait_irq(n);
    wr(1, 8'd3);
    wait_irq(n1);
    wait_irq(n2);
    chk("R4 old compare kept", n1 + 2, 10);
    chk("R4 new compare after reload", n2, 4);
    wr(0, ctl(0, 0, 0));
    idle(2);
    chk("R4 stopped count", count_o, 0);
    chk("R4 stopped output", tmr_o, 0);

    // R5 event counting
    wr(1, 8'd4);
    wr(0, ctl(0, 11, 1));
    base = irq_cnt;
    for (int p = 0; p < 3; p++) begin
      event_i = 1'b1; idle(2); event_i = 1'b0; idle(2);
    end
    idle(4);
    chk("R5 three events", count_o, 3);
    for (int p = 0; p < 2; p++) begin
      event_i = 1'b1; idle(2); event_i = 1'b0; idle(2);
    end
    idle(4);
    chk("R5 wrap count", count_o, 0);
    chk("R5 one irq", irq_cnt - base, 1);
    chk("R5 output toggled", tmr_o, 1);

    // R6 R7 PWM with fraction
    foreach (n_arr_d[i]) begin
      for (int a = 0; a < 4; a++) begin
        wr(0, ctl(1, 0, 0));
        wr(1, 8'(n_arr_d[i]));
        wr(2, 8'(a));
        wr(0, ctl(1, 0, 1));
        base = irq_cnt;
        for (int p = 0; p < 4; p++) begin
          int ex;
          hi = 0;
          for (int k = 0; k < 256; k++) begin
            if (tmr_o) hi++;
            @(negedge clk_i);
          end
          ex = (a == 3) ? int'(p != 3) :
               (a == 2) ? int'(p == 0 || p == 2) :
               (a == 1) ? int'(p == 0) : 0;
          chk($sformatf("R7 duty=%0d frac=%0d period %0d", n_arr_d[i], a, p),
              hi, n_arr_d[i] + ex);
        end
        chk("R6 wrap irqs", irq_cnt - base, 3);
      end
    end

    // R8 gate width capture
    wr(0, ctl(2, 0, 0));
    wr(0, ctl(2, 0, 1));
    foreach (n_arr_w[i]) begin
      w = n_arr_w[i];
      base = irq_cnt;
      gate_i = 1'b1;
      idle(w);
      gate_i = 1'b0;
      idle(6);
      chk($sformatf("R8 width %0d", w), count_o, (w > 255) ? 255 : w);
      chk("R8 irq on fall", irq_cnt - base, 1);
      chk("R8 output low", tmr_o, 0);
    end

    // R9 R10 trip override
    tick_i = '0;
    wr(1, 8'd255);
    wr(0, ctl(1, 0, 1));
    idle(1);
    chk("R9 pwm level high", tmr_o, 1);
    wr(3, 8'h05);
    trip_n_i = 1'b0; idle(5);
    chk("R9 forced low", tmr_o, 0);
    chk("R9 forced low oe", tmr_oe_o, 1);
    idle(50);
    chk("R9 held low", tmr_o, 0);
    trip_n_i = 1'b1; idle(5);
    chk("R10 rising edge ignored", tmr_o, 0);
    wr(3, 8'h0D);
    idle(1);
    chk("R9 cleared", tmr_o, 1);
    wr(3, 8'h06);
    trip_n_i = 1'b0; idle(5);
    chk("R9 hi-z oe", tmr_oe_o, 0);
    chk("R9 hi-z pin", tmr_o, 0);
    trip_n_i = 1'b1; idle(5);
    wr(3, 8'h0E);
    idle(1);
    chk("R9 hi-z cleared", tmr_oe_o, 1);
    wr(0, ctl(1, 0, 0));
    wr(3, 8'h04);
    idle(1);
    chk("R9 stopped low", tmr_o, 0);
    trip_n_i = 1'b0; idle(5);
    chk("R9 forced high", tmr_o, 1);
    trip_n_i = 1'b1; idle(5);
    wr(3, 8'h0C);
    idle(1);
    chk("R9 high cleared", tmr_o, 0);
    wr(0, ctl(1, 0, 1));
    wr(3, 8'h01);
    trip_n_i = 1'b0; idle(5);
    chk("R10 disarmed pin", tmr_o, 1);
    chk("R10 disarmed oe", tmr_oe_o, 1);
    trip_n_i = 1'b1; idle(5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  int n_arr_c[6] = '{0, 1, 2, 7, 30, 255};
  int n_arr_d[5] = '{0, 1, 64, 200, 255};
  int n_arr_w[7] = '{1, 2, 5, 40, 255, 256, 300};
endmodule